// File: doc/BRIEF.md
# String Load Sequencer

This block carries out a load-string operation for an execution pipeline. A `start` pulse brings in the opcode byte, the operand-size and 64-bit-promotion controls, the address mode, the direction flag, the repeat request and the starting accumulator, index and count values. The block then fetches one or more elements from memory at the source index. It merges each element into the accumulator lane that matches its size. After each element it moves the index forward or backward by the element size, wrapping within the active address width.

The memory side uses a plain request/response handshake. `mem_req` stays high with a stable address and size code until `mem_rsp_valid` arrives. A response may carry a fault, which aborts the element in progress. When repeat is requested, the count register sets the number of elements. The count is decremented in the active address width, and a zero count finishes at once with no request. The block changes no status flags.

Top module: `strld_seq`

## Requirements
- R1: Opcode 0xAC selects a byte element. Opcode 0xAD selects a word when `opsz32`=0 and a doubleword when `opsz32`=1. It selects a quadword when `rex_w`=1 and `amode` is 64-bit. `rex_w` is ignored in the other address modes. `amode` encoding: 2'b00 = 16-bit, 2'b01 = 32-bit, 2'b1x = 64-bit.
- R2: A byte element replaces accumulator bits [7:0] and a word replaces bits [15:0]; in both cases the other accumulator bits are kept. A doubleword writes bits [31:0] and clears bits [63:32]. A quadword writes all 64 bits.
- R3: After each good element the index moves by 1, 2, 4 or 8 (the element size). It increases when `dir_flag`=0 and decreases when `dir_flag`=1.
- R4: In 16-bit mode only index bits [15:0] change, modulo 2^16, and bits [63:16] are kept. In 32-bit mode only bits [31:0] change, modulo 2^32. In 64-bit mode the full register changes.
- R5: With `rep`=1 the block performs as many elements as the count holds in the active address width. It decrements the count once per completed element, within that width. The accumulator ends holding the last element.
- R6: With `rep`=1 and a count whose active-width part is zero, no request is issued. The accumulator, index and count equal the start values, and `done` pulses in the cycle after `start`.
- R7: A response with `mem_rsp_fault`=1 aborts the element. The accumulator, index and count keep the values they held before that element, and `done` and `done_fault` pulse together. Elements completed before the fault stay committed.
- R8: `mem_addr` equals the index masked to the active address width, and `mem_size` carries log2 of the element size in bytes. `mem_req` rises in the cycle after an accepted `start` and holds its address steady until a response.
- R9: `start` is ignored while `busy` is high. It is also ignored when the opcode is neither 0xAC nor 0xAD: in that case there is no `busy`, no request and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| opcode | input | 8 | Opcode byte |
| opsz32 | input | 1 | Operand size is 32 bits when 1, 16 bits when 0 |
| rex_w | input | 1 | 64-bit operand promotion |
| amode | input | 2 | Address mode: 00 16-bit, 01 32-bit, 1x 64-bit |
| dir_flag | input | 1 | 0 increments, 1 decrements the index |
| rep | input | 1 | Repeat under the count register |
| acc_in | input | 64 | Starting accumulator |
| idx_in | input | 64 | Starting source index |
| cnt_in | input | 64 | Starting count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Completion was caused by a fault |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Read address |
| mem_size | output | 2 | log2 of element bytes |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 64 | Response data, element in low bits |
| mem_rsp_fault | input | 1 | Response carries a fault |
| acc_out | output | 64 | Accumulator |
| idx_out | output | 64 | Source index |
| cnt_out | output | 64 | Count register |

## Verification
Two events can fall in the same cycle: the fault abort and the completion of the last repeated element, when the count would reach zero. The bench provokes this by placing the faulting address at the final element of a repeated load. It then expects the fault to win: the count stays at one, the index and accumulator reflect only the elements already committed, and `done` coincides with `done_fault`. A second collision puts a fresh `start` in a cycle where the sequencer is still busy, and the bench judges it by the final registers matching only the first operation.

// File: rtl/strld_pkg.sv
package strld_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2, SZ_Q = 2'd3} elem_sz_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_state_e;
  localparam logic [7:0] OPC_LD_BYTE = 8'hAC;
  localparam logic [7:0] OPC_LD_VAR  = 8'hAD;
endpackage

// File: rtl/strld_decode.sv
module strld_decode
  import strld_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       opsz32,
  input  logic       rex_w,
  input  logic [1:0] amode,
  output logic       valid,
  output elem_sz_e   sz
);
  always_comb begin
    valid = (opcode == OPC_LD_BYTE) || (opcode == OPC_LD_VAR);
    if (opcode == OPC_LD_BYTE)     sz = SZ_B;
    else if (rex_w && amode[1])    sz = SZ_Q;
    else if (opsz32)               sz = SZ_D;
    else                           sz = SZ_W;
  end
endmodule

// File: rtl/strld_wrap_step.sv
module strld_wrap_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] delta,
  input  logic         sub,
  input  logic [W-1:0] keep_mask,
  output logic [W-1:0] res
);
  logic [W-1:0] sum;
  always_comb begin
    sum = sub ? (base - delta) : (base + delta);
    res = (sum & keep_mask) | (base & ~keep_mask);
  end
endmodule

// File: rtl/strld_acc_merge.sv
module strld_acc_merge
  import strld_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] acc,
  input  logic [XLEN-1:0] data,
  input  elem_sz_e        sz,
  output logic [XLEN-1:0] merged
);
  localparam int HALF = XLEN / 2;
  always_comb begin
    case (sz)
      SZ_B:    merged = {acc[XLEN-1:8], data[7:0]};
      SZ_W:    merged = {acc[XLEN-1:16], data[15:0]};
      SZ_D:    merged = {{(XLEN-HALF){1'b0}}, data[HALF-1:0]};
      default: merged = data;
    endcase
  end
endmodule

// File: rtl/strld_seq.sv
module strld_seq
  import strld_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic            opsz32,
  input  logic            rex_w,
  input  logic [1:0]      amode,
  input  logic            dir_flag,
  input  logic            rep,
  input  logic [XLEN-1:0] acc_in,
  input  logic [XLEN-1:0] idx_in,
  input  logic [XLEN-1:0] cnt_in,
  output logic            busy,
  output logic            done,
  output logic            done_fault,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  output logic [1:0]      mem_size,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_fault,
  output logic [XLEN-1:0] acc_out,
  output logic [XLEN-1:0] idx_out,
  output logic [XLEN-1:0] cnt_out
);
  localparam logic [XLEN-1:0] MASK16 = {{(XLEN-16){1'b0}}, {16{1'b1}}};
  localparam logic [XLEN-1:0] MASK32 = {{(XLEN-32){1'b0}}, {32{1'b1}}};
  localparam logic [XLEN-1:0] MASK64 = {XLEN{1'b1}};
  localparam logic [XLEN-1:0] ONE    = {{(XLEN-1){1'b0}}, 1'b1};

  function automatic logic [XLEN-1:0] width_mask(input logic [1:0] am);
    if (am == 2'b00)      return MASK16;
    else if (am == 2'b01) return MASK32;
    else                  return MASK64;
  endfunction

  seq_state_e      state_q;
  elem_sz_e        sz_q, dec_sz;
  logic            dec_valid;
  logic [1:0]      amode_q;
  logic            dir_q, rep_q;
  logic [XLEN-1:0] acc_q, idx_q, cnt_q;
  logic            req_q, done_q, fault_q;
  logic [XLEN-1:0] mask_run, mask_start;
  logic [XLEN-1:0] idx_nxt, cnt_nxt, acc_nxt, step;
  logic            accept_start, rsp_ok, rsp_bad, start_zero;

  strld_decode u_dec (
    .opcode(opcode), .opsz32(opsz32), .rex_w(rex_w), .amode(amode),
    .valid(dec_valid), .sz(dec_sz)
  );

  always_comb begin
    mask_run   = width_mask(amode_q);
    mask_start = width_mask(amode);
    step       = ONE << sz_q;
    accept_start = (state_q == ST_IDLE) && start && dec_valid;
    start_zero   = rep && ((cnt_in & mask_start) == '0);
    rsp_ok       = (state_q == ST_WAIT) && mem_rsp_valid && !mem_rsp_fault;
    rsp_bad      = (state_q == ST_WAIT) && mem_rsp_valid && mem_rsp_fault;
  end

  strld_wrap_step #(.W(XLEN)) u_idx_step (
    .base(idx_q), .delta(step), .sub(dir_q), .keep_mask(mask_run), .res(idx_nxt)
  );

  strld_wrap_step #(.W(XLEN)) u_cnt_step (
    .base(cnt_q), .delta(ONE), .sub(1'b1), .keep_mask(mask_run), .res(cnt_nxt)
  );

  strld_acc_merge #(.XLEN(XLEN)) u_merge (
    .acc(acc_q), .data(mem_rsp_data), .sz(sz_q), .merged(acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sz_q    <= SZ_B;
      amode_q <= 2'b00;
      dir_q   <= 1'b0;
      rep_q   <= 1'b0;
      acc_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (accept_start) begin
        sz_q    <= dec_sz;
        amode_q <= amode;
        dir_q   <= dir_flag;
        rep_q   <= rep;
        acc_q   <= acc_in;
        idx_q   <= idx_in;
        cnt_q   <= cnt_in;
        if (start_zero) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_WAIT;
          req_q   <= 1'b1;
        end
      end else if (rsp_bad) begin
        state_q <= ST_IDLE;
        req_q   <= 1'b0;
        done_q  <= 1'b1;
        fault_q <= 1'b1;
      end else if (rsp_ok) begin
        acc_q <= acc_nxt;
        idx_q <= idx_nxt;
        if (rep_q) cnt_q <= cnt_nxt;
        if (!rep_q || ((cnt_nxt & mask_run) == '0)) begin
          state_q <= ST_IDLE;
          req_q   <= 1'b0;
          done_q  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    busy       = (state_q == ST_WAIT);
    done       = done_q;
    done_fault = fault_q;
    mem_req    = req_q;
    mem_addr   = idx_q & mask_run;
    mem_size   = sz_q;
    acc_out    = acc_q;
    idx_out    = idx_q;
    cnt_out    = cnt_q;
  end

  assert_req_inside_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));

  assert_fault_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_bad |=> ($stable(acc_out) && $stable(idx_out) && $stable(cnt_out) && done && done_fault));

  assert_zero_count_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    (accept_start && start_zero) |=> (done && !mem_req && !busy));

  assert_upper_index_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_ok && amode_q == 2'b00) |=> (idx_out[XLEN-1:16] == $past(idx_out[XLEN-1:16])));

  assert_count_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_ok && rep_q) |=> (cnt_out != $past(cnt_out)));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !mem_rsp_valid) |=> ($stable(idx_out) && $stable(acc_out)));
endmodule

// File: tb/tb_strld_seq.sv
module tb_strld_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic [7:0]  op;
    logic        o32;
    logic        rw;
    logic [1:0]  am;
    logic        df;
    logic        rp;
    logic [63:0] idx;
    logic [15:0] cnt;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'hAC, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 64'h1111_2222_3333_FFFF, 16'd0},
    '{8'hAD, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 64'h4444_5555_6666_0001, 16'd0},
    '{8'hAD, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 64'hAAAA_0000_FFFF_FFF8, 16'd3},
    '{8'hAD, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 64'h0000_0000_0001_0000, 16'd2},
    '{8'hAD, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 64'h0000_0000_0000_1000, 16'd0},
    '{8'hAC, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 64'h0000_0000_0000_2000, 16'd0},
    '{8'hAD, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 64'h0000_0001_0000_3000, 16'd0},
    '{8'hAC, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 64'h0000_0000_0000_0002, 16'd4},
    '{8'hAD, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 16'd1},
    '{8'hAC, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 64'h0000_0000_0000_4000, 16'd0}
  };

  localparam logic [63:0] ACC0 = 64'hA5A5_5A5A_C3C3_3C3C;

  logic        clk = 1'b0, rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        opsz32 = 1'b0, rex_w = 1'b0, dir_flag = 1'b0, rep = 1'b0;
  logic [1:0]  amode = 2'b00;
  logic [63:0] acc_in = '0, idx_in = '0, cnt_in = '0;
  logic        busy, done, done_fault, mem_req;
  logic [63:0] mem_addr, acc_out, idx_out, cnt_out, mem_rsp_data;
  logic [1:0]  mem_size;
  logic        mem_rsp_valid = 1'b0, mem_rsp_fault;
  logic        fault_en = 1'b0;
  logic [63:0] fault_addr = '0;
  int          nreq = 0;
  int          tests = 0, fails = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] memf(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  assign mem_rsp_data  = memf(mem_addr);
  assign mem_rsp_fault = fault_en && (mem_addr == fault_addr);

  always @(negedge clk) begin
    if (rst) mem_rsp_valid <= 1'b0;
    else     mem_rsp_valid <= mem_req && !mem_rsp_valid;
  end

  always @(posedge clk) if (mem_req && mem_rsp_valid) nreq <= nreq + 1;

  strld_seq dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .opsz32(opsz32),
    .rex_w(rex_w), .amode(amode), .dir_flag(dir_flag), .rep(rep),
    .acc_in(acc_in), .idx_in(idx_in), .cnt_in(cnt_in),
    .busy(busy), .done(done), .done_fault(done_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_fault(mem_rsp_fault),
    .acc_out(acc_out), .idx_out(idx_out), .cnt_out(cnt_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_size(input vec_t v);
    if (v.op == 8'hAC)       return 2'd0;
    if (v.rw && v.am[1])     return 2'd3;
    return v.o32 ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [63:0] ref_mask(input logic [1:0] am);
    if (am == 2'b00) return 64'h0000_0000_0000_FFFF;
    if (am == 2'b01) return 64'h0000_0000_FFFF_FFFF;
    return '1;
  endfunction

  function automatic logic [63:0] cnt_of(input vec_t v);
    return v.am[1] ? {48'h0, v.cnt} : {32'h1234_5678, 16'h0, v.cnt};
  endfunction

  // Expected registers after `limit` completed elements (from R1..R5)
  task automatic model(input vec_t v, input int limit,
                       output logic [63:0] ea, output logic [63:0] ei, output logic [63:0] ec);
    logic [63:0] m, d, nx;
    logic [1:0]  s;
    s = ref_size(v); m = ref_mask(v.am);
    ea = ACC0; ei = v.idx; ec = cnt_of(v);
    for (int k = 0; k < limit; k++) begin
      d = memf(ei & m);
      case (s)
        2'd0: ea = {ea[63:8], d[7:0]};
        2'd1: ea = {ea[63:16], d[15:0]};
        2'd2: ea = {32'h0, d[31:0]};
        default: ea = d;
      endcase
      nx = v.df ? ei - (64'd1 << s) : ei + (64'd1 << s);
      ei = (nx & m) | (ei & ~m);
      if (v.rp) ec = ((ec - 64'd1) & m) | (ec & ~m);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    opcode = v.op; opsz32 = v.o32; rex_w = v.rw; amode = v.am;
    dir_flag = v.df; rep = v.rp; acc_in = ACC0; idx_in = v.idx; cnt_in = cnt_of(v);
    nreq = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic flt);
    int t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    if (!done) begin
      fails++; tests++;
      $display("FAIL R5 actual=timeout expected=done");
    end
    flt = done_fault;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] ea, ei, ec;
    logic flt;
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset busy",  {63'h0, busy}, 64'd0);
    chk("reset req",   {63'h0, mem_req}, 64'd0);
    chk("reset done",  {63'h0, done}, 64'd0);
    chk("reset acc",   acc_out, 64'd0);
    chk("reset idx",   idx_out, 64'd0);

    // Table walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      launch(v);
      if (v.rp && ((cnt_of(v) & ref_mask(v.am)) == 64'd0)) begin
        chk("R6 done next cycle", {63'h0, done}, 64'd1);
        chk("R6 no request", {63'h0, mem_req}, 64'd0);
        model(v, 0, ea, ei, ec);
      end else begin
        chk("R8 req raised", {63'h0, mem_req}, 64'd1);
        chk("R8 addr masked", mem_addr, v.idx & ref_mask(v.am));
        chk("R1 size code", {62'h0, mem_size}, {62'h0, ref_size(v)});
        model(v, v.rp ? int'(v.cnt) : 1, ea, ei, ec);
      end
      wait_done(flt);
      chk("R2 accumulator", acc_out, ea);
      chk("R3 R4 index", idx_out, ei);
      chk("R5 count", cnt_out, ec);
      chk("R5 requests", 64'(nreq), v.rp ? 64'(v.cnt) : 64'd1);
      chk("R7 no fault", {63'h0, flt}, 64'd0);
    end

    // R7: fault on the final repeated element collides with count reaching zero
    v = '{8'hAD, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 64'h0000_0000_0000_5000, 16'd3};
    fault_en = 1'b1; fault_addr = 64'h5008;
    launch(v);
    wait_done(flt);
    model(v, 2, ea, ei, ec);
    chk("R7 fault flag", {63'h0, flt}, 64'd1);
    chk("R7 acc kept", acc_out, ea);
    chk("R7 idx kept", idx_out, ei);
    chk("R7 cnt kept", cnt_out, ec);
    chk("R7 requests", 64'(nreq), 64'd3);
    fault_en = 1'b0;
    @(negedge clk);
    chk("R7 idle after fault", {63'h0, busy}, 64'd0);

    // R9: invalid opcode ignored
    @(negedge clk);
    opcode = 8'hAB; rep = 1'b0; idx_in = 64'h7777; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 bad opcode busy", {63'h0, busy}, 64'd0);
    chk("R9 bad opcode req", {63'h0, mem_req}, 64'd0);
    chk("R9 bad opcode done", {63'h0, done}, 64'd0);
    chk("R9 bad opcode idx", idx_out, ei);

    // R9: start while busy ignored
    v = '{8'hAC, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 64'h0000_0000_0000_6000, 16'd3};
    launch(v);
    opcode = 8'hAD; rex_w = 1'b1; idx_in = 64'h9999_0000; acc_in = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(flt);
    model(v, 3, ea, ei, ec);
    chk("R9 busy start acc", acc_out, ea);
    chk("R9 busy start idx", idx_out, ei);
    chk("R9 busy start cnt", cnt_out, ec);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule